// File: doc/BRIEF.md
# Iterative DES and Triple-DES Block Cipher Engine

This block enciphers or deciphers a single 64-bit block with DES. It is built for minimum area and a short logic path, not for throughput. One round datapath serves every Feistel round, one round per clock, and the round subkeys are derived from the key on the fly. A triple mode chains three DES passes with separate keys. On encryption the passes run encrypt, decrypt, encrypt. On decryption the key order is reversed and the passes run decrypt, encrypt, decrypt.

The host places the block, the keys and the mode on the inputs and pulses `start`. All of them are captured on that edge. `busy` stays high while the engine works. `done` pulses for one cycle when the result appears on `data_out`. The result stays there until a later operation completes.

Each DES pass takes one cycle for the initial permutation and subkey load, sixteen round cycles, and one cycle for the final permutation. A single pass therefore finishes 18 cycles after the start edge, and a triple operation finishes after 54.

Top module: `des3_iter_core`

## Requirements
- R1: While `rst_n` is low and after its release, `busy` and `done` are 0 and `data_out` is all zeros until the first operation completes.
- R2: With `triple`=0 and `decrypt`=0, `data_out` equals the standard DES encryption of `data_in` under `key1`. Key bits 8, 16, ... 64 (the parity bits) are not used.
- R3: With `triple`=0 and `decrypt`=1, `data_out` is the DES decryption under `key1`, so decrypting a ciphertext under the key that produced it returns the original block.
- R4: With `triple`=1 and `decrypt`=0, the result is E(key3, D(key2, E(key1, block))), where E is DES encryption and D is DES decryption.
- R5: With `triple`=1 and `decrypt`=1, the result is D(key1, E(key2, D(key3, block))).
- R6: `done` rises exactly 18 clock edges after the accepting start edge in single mode and 54 in triple mode. `busy` is 1 from the cycle after acceptance through the cycle before `done`, and is 0 in the `done` cycle.
- R7: A `start` seen while `busy` is 1 is ignored. It neither changes the running result or its timing nor queues a later operation.
- R8: `done` is high for exactly one cycle, and `data_out` changes only in a cycle where `done` is 1.
- R9: `data_in`, the keys, `triple` and `decrypt` are sampled only on the accepting start edge. Changes to them while `busy` have no effect on the result.
- R10: In single mode, `key2` and `key3` have no effect on the result.
- R11: A `start` presented in the same cycle as `done` is accepted, and the new operation runs with full latency and a correct result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; accepted only when `busy` is 0 |
| triple | input | 1 | 1 selects three chained DES passes |
| decrypt | input | 1 | 1 selects the decryption direction |
| data_in | input | 64 | Block to process, MSB is DES bit 1 |
| key1 | input | 64 | First key (the only key used in single mode) |
| key2 | input | 64 | Second key (triple mode) |
| key3 | input | 64 | Third key (triple mode) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse marking a new result |
| data_out | output | 64 | Result block, held between completions |

## Verification
Two events can fall in the same cycle. One is the completion pulse of one operation and the acceptance of the next `start`. The other is a `start` issued during a running operation, which must be turned away. The bench provokes the first by raising `start` with a fresh vector in the very cycle where it sees `done`. It then requires `busy` on the next cycle, a full 18-cycle latency and a correct second result. It provokes the second by pulsing `start` mid-operation with altered data, keys and mode. It then requires the original result, the original latency and no follow-on operation.

// File: rtl/des3_iter_core.sv
module des3_iter_core (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        triple,
  input  logic        decrypt,
  input  logic [63:0] data_in,
  input  logic [63:0] key1,
  input  logic [63:0] key2,
  input  logic [63:0] key3,
  output logic        busy,
  output logic        done,
  output logic [63:0] data_out
);

  typedef enum logic [1:0] {S_IDLE, S_INIT, S_RND, S_FIN} state_t;

  localparam int KSEL [56] = '{
    57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
    10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
    14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};

  localparam int RSEL [48] = '{
    14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
    23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

  localparam int PMIX [32] = '{
    16,  7, 20, 21, 29, 12, 28, 17,  1, 15, 23, 26,  5, 18, 31, 10,
     2,  8, 24, 14, 32, 27,  3,  9, 19, 13, 30,  6, 22, 11,  4, 25};

  function automatic int ip_src(input int j);
    int r, c, b;
    r = j / 8;
    c = j % 8;
    b = (r < 4) ? 58 + 2 * r : 57 + 2 * (r - 4);
    return b - 8 * c;
  endfunction

  function automatic logic [63:0] perm_in(input logic [63:0] x);
    logic [63:0] y;
    for (int j = 0; j < 64; j++) y[63-j] = x[64-ip_src(j)];
    return y;
  endfunction

  function automatic logic [63:0] perm_out(input logic [63:0] x);
    logic [63:0] y;
    for (int j = 0; j < 64; j++) y[64-ip_src(j)] = x[63-j];
    return y;
  endfunction

  function automatic logic [55:0] key_pick(input logic [63:0] k);
    logic [55:0] y;
    for (int i = 0; i < 56; i++) y[55-i] = k[64-KSEL[i]];
    return y;
  endfunction

  function automatic logic [47:0] sub_pick(input logic [55:0] cd);
    logic [47:0] y;
    for (int i = 0; i < 48; i++) y[47-i] = cd[56-RSEL[i]];
    return y;
  endfunction

  function automatic logic [3:0] sbox(input int n, input logic [5:0] x);
    logic [255:0] t;
    int idx;
    case (n)
      0: t = 256'hE4D12FB83A6C59070F74E2D1A6CB953841E8D62BFC973A50FC8249175B3EA06D;
      1: t = 256'hF18E6B34972DC05A3D47F28EC01A69B50E7BA4D158C6932FD8A13F42B67C05E9;
      2: t = 256'hA09E63F51DC7B428D70934A6285ECBF1D6498F30B12C5AE71AD069874FE3B52C;
      3: t = 256'h7DE3069A1285BC4FD8B56F03472C1AE9A690CB7DF13E52843F06A1D8945BC72E;
      4: t = 256'h2C417AB6853FD0E9EB2C47D150FA3986421BAD78F9C5630EB8C71E2D6F09A453;
      5: t = 256'hC1AF92680D34E75BAF427C9561DE0B389EF528C3704A1DB6432C95FABE17608D;
      6: t = 256'h4B2EF08D3C975A61D0B7491AE35C2F8614BDC37EAF6805926BD814A7950FE23C;
      default: t = 256'hD2846FB1A93E50C71FD8A374C56B0E927B419CE206ADF35821E74A8DFC90356B;
    endcase
    idx = int'({x[5], x[0], x[4:1]});
    return t[255-4*idx -: 4];
  endfunction

  function automatic logic [31:0] feistel(input logic [31:0] r, input logic [47:0] k);
    logic [47:0] e;
    logic [31:0] s, p;
    for (int j = 0; j < 8; j++)
      for (int b = 0; b < 6; b++)
        e[47-(6*j+b)] = r[31-((4*j+b+31) % 32)];
    e = e ^ k;
    for (int j = 0; j < 8; j++) s[31-4*j -: 4] = sbox(j, e[47-6*j -: 6]);
    for (int i = 0; i < 32; i++) p[31-i] = s[32-PMIX[i]];
    return p;
  endfunction

  function automatic logic [27:0] rot28(input logic [27:0] x, input logic left, input logic [1:0] n);
    case ({left, n})
      3'b101:  return {x[26:0], x[27]};
      3'b110:  return {x[25:0], x[27:26]};
      3'b001:  return {x[0], x[27:1]};
      3'b010:  return {x[1:0], x[27:2]};
      default: return x;
    endcase
  endfunction

  state_t      st;
  logic [3:0]  rnd;
  logic [1:0]  pass;
  logic        tq, dq, done_q;
  logic [63:0] lr, res, k1q, k2q, k3q;
  logic [55:0] cd;

  logic        pass_dec, edge_rnd, last_pass;
  logic [1:0]  shamt;
  logic [63:0] pass_key, fin_blk;
  logic [55:0] cd_next;
  logic [47:0] subkey;

  assign pass_dec  = dq ^ (pass == 2'd1);
  assign pass_key  = (pass == 2'd1) ? k2q : (((pass == 2'd0) != (dq && tq)) ? k1q : k3q);
  assign last_pass = !tq || (pass == 2'd2);
  assign edge_rnd  = (rnd == 4'd1) || (rnd == 4'd8) || (rnd == 4'd15);
  assign shamt     = pass_dec ? ((rnd == 4'd0) ? 2'd0 : (edge_rnd ? 2'd1 : 2'd2))
                              : (((rnd == 4'd0) || edge_rnd) ? 2'd1 : 2'd2);
  assign cd_next   = {rot28(cd[55:28], !pass_dec, shamt), rot28(cd[27:0], !pass_dec, shamt)};
  assign subkey    = sub_pick(cd_next);
  assign fin_blk   = perm_out({lr[31:0], lr[63:32]});

  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign data_out = res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      rnd <= '0;
      pass <= '0;
      tq <= 1'b0;
      dq <= 1'b0;
      done_q <= 1'b0;
      lr <= '0;
      res <= '0;
      k1q <= '0;
      k2q <= '0;
      k3q <= '0;
      cd <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          lr <= data_in;
          k1q <= key1;
          k2q <= key2;
          k3q <= key3;
          tq <= triple;
          dq <= decrypt;
          pass <= 2'd0;
          st <= S_INIT;
        end
        S_INIT: begin
          lr <= perm_in(lr);
          cd <= key_pick(pass_key);
          rnd <= 4'd0;
          st <= S_RND;
        end
        S_RND: begin
          lr <= {lr[31:0], lr[63:32] ^ feistel(lr[31:0], subkey)};
          cd <= cd_next;
          rnd <= rnd + 4'd1;
          if (rnd == 4'd15) st <= S_FIN;
        end
        default: begin
          if (last_pass) begin
            res <= fin_blk;
            done_q <= 1'b1;
            st <= S_IDLE;
          end else begin
            lr <= fin_blk;
            pass <= pass + 2'd1;
            st <= S_INIT;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/des3_iter_core_chk.sv
module des3_iter_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        triple,
  input logic        busy,
  input logic        done,
  input logic [63:0] data_out
);

  logic [6:0] cyc;
  logic       mode3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= '0;
      mode3 <= 1'b0;
    end else if (start && !busy) begin
      cyc <= '0;
      mode3 <= triple;
    end else if (busy) begin
      cyc <= cyc + 7'd1;
    end
  end

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(data_out));
  p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
                                 done |-> (cyc == (mode3 ? 7'd54 : 7'd18)));

endmodule

bind des3_iter_core des3_iter_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .triple(triple),
  .busy(busy), .done(done), .data_out(data_out)
);

// File: tb/des3_iter_core_tb.sv
module des3_iter_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] KA = 64'h133457799BBCDFF1;
  localparam logic [63:0] KB = 64'h0E329232EA6D0D73;
  localparam logic [63:0] KC = 64'h0123456789ABCDEF;
  localparam logic [63:0] JK = 64'hA5A55A5A3C3CC3C3;
  localparam logic [63:0] P0 = 64'h0123456789ABCDEF;
  localparam logic [63:0] C0 = 64'h85E813540F0AB405;

  // {triple, decrypt, key1, key2, key3, data_in, expected}
  localparam int NV = 10;
  localparam logic [321:0] VEC [NV] = '{
    {1'b0, 1'b0, KA, JK, ~JK, P0, C0},
    {1'b0, 1'b1, KA, ~JK, JK, C0, P0},
    {1'b0, 1'b0, KB, JK, JK, 64'h8787878787878787, 64'h0000000000000000},
    {1'b0, 1'b1, KB, KA, KC, 64'h0000000000000000, 64'h8787878787878787},
    {1'b0, 1'b0, KC, KB, KA, 64'h4E6F772069732074, 64'h3FA40E8A984D4815},
    {1'b1, 1'b0, KA, KA, KA, P0, C0},
    {1'b1, 1'b0, KB, KB, KA, P0, C0},
    {1'b1, 1'b0, KA, KB, KB, P0, C0},
    {1'b1, 1'b1, KA, KB, KB, C0, P0},
    {1'b1, 1'b1, KB, KB, KA, C0, P0}
  };

  logic clk = 1'b0;
  logic rst_n, start, triple, decrypt;
  logic [63:0] data_in, key1, key2, key3;
  logic busy, done;
  logic [63:0] data_out;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  des3_iter_core dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .triple(triple), .decrypt(decrypt),
    .data_in(data_in), .key1(key1), .key2(key2), .key3(key3),
    .busy(busy), .done(done), .data_out(data_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic t, input logic d, input logic [63:0] k1, input logic [63:0] k2,
                        input logic [63:0] k3, input logic [63:0] din);
    triple = t; decrypt = d; key1 = k1; key2 = k2; key3 = k3; data_in = din;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic await(output int n, input int poke, input bit poke_start);
    n = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
      if (n == poke) begin
        start = poke_start;
        data_in = ~data_in; key1 = ~key1; key2 = ~key2; key3 = ~key3;
        triple = ~triple; decrypt = ~decrypt;
      end else if (n == poke + 1) begin
        start = 1'b0;
      end
    end
  endtask

  task automatic run_vec(input int i, input int poke, input bit poke_start, input string tag);
    int n;
    logic [321:0] v;
    v = VEC[i];
    launch(v[321], v[320], v[319:256], v[255:192], v[191:128], v[127:64]);
    chk(busy === 1'b1, {tag, " R6 busy after accept"}, {63'd0, busy}, 64'd1);
    await(n, poke, poke_start);
    chk(data_out === v[63:0], tag, data_out, v[63:0]);
    chk(n == (v[321] ? 54 : 18), {tag, " R6 latency"}, 64'(n), v[321] ? 64'd54 : 64'd18);
  endtask

  function automatic logic [63:0] xs64(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    return y ^ (y << 17);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    logic [63:0] s, ct, pt, hold, ka, kb, kc;
    rst_n = 1'b0; start = 1'b0; triple = 1'b0; decrypt = 1'b0;
    data_in = '0; key1 = '0; key2 = '0; key3 = '0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 flags in reset", {62'd0, busy, done}, 64'd0);
    chk(data_out === 64'd0, "R1 output in reset", data_out, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && data_out === 64'd0, "R1 after release", data_out, 64'd0);

    // table walk: R2 R3 R10 single, R4 R5 triple
    for (int i = 0; i < NV; i++) begin
      run_vec(i, -5, 1'b0, $sformatf("R2/R3/R4/R5/R10 vector %0d", i));
      @(negedge clk);
    end

    // R8: one-cycle done and held output
    run_vec(0, -5, 1'b0, "R8 base");
    hold = data_out;
    @(negedge clk);
    chk(done === 1'b0, "R8 done one cycle", {63'd0, done}, 64'd0);
    data_in = ~data_in; key1 = ~key1; decrypt = 1'b1;
    repeat (3) @(negedge clk);
    chk(data_out === hold && busy === 1'b0, "R8 output held", data_out, hold);

    // R7: start while busy ignored, nothing queued
    run_vec(4, 6, 1'b1, "R7 start while busy");
    repeat (4) begin
      @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0, "R7 no queued start", {62'd0, busy, done}, 64'd0);
    end

    // R9: inputs altered while busy without start
    run_vec(7, 10, 1'b0, "R9 inputs changed while busy");
    @(negedge clk);

    // R11: start in the done cycle
    run_vec(0, -5, 1'b0, "R11 first op");
    begin
      logic [321:0] v;
      v = VEC[4];
      launch(v[321], v[320], v[319:256], v[255:192], v[191:128], v[127:64]);
      chk(busy === 1'b1, "R11 accepted with done", {63'd0, busy}, 64'd1);
      await(n, -5, 1'b0);
      chk(data_out === v[63:0], "R11 second result", data_out, v[63:0]);
      chk(n == 18, "R11 second latency", 64'(n), 64'd18);
    end
    @(negedge clk);

    // R3 R5: round trips on pseudo-random data
    s = 64'h9E3779B97F4A7C15;
    for (int t = 0; t < 8; t++) begin
      s = xs64(s); pt = s;
      s = xs64(s); ka = s;
      s = xs64(s); kb = s;
      s = xs64(s); kc = s;
      launch(t[0], 1'b0, ka, kb, kc, pt);
      await(n, -5, 1'b0);
      ct = data_out;
      @(negedge clk);
      launch(t[0], 1'b1, ka, kb, kc, ct);
      await(n, -5, 1'b0);
      chk(data_out === pt, t[0] ? "R5 triple round trip" : "R3 single round trip", data_out, pt);
      @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule